// File: doc/BRIEF.md
# Integer Arithmetic/Logic Unit with Overflow Flag

This block is the combinational core that computes integer results for a load/store processor datapath. It takes two operands and a 4-bit operation select in the same cycle. It returns a result word, a flag that is high when the result is all zeros, and an overflow flag. It supports addition and subtraction in trapping and non-trapping forms, four bitwise operations, and signed and unsigned less-than comparisons. Immediate extension, shifts, multiply, divide and exception handling all happen outside the block.

Subtraction uses the same adder as addition. Operand B is inverted and a carry of one enters bit 0. Overflow comes from comparing the carry into the top bit with the carry out of it. The overflow flag is raised only when the selected operation is a trapping add or subtract. The comparisons return the answer in bit 0 and clear every other result bit. An equality test is made by subtracting and reading the zero flag.

Top module: `int_alu`

## Requirements
- R1: Select 0000 gives A AND B, 0001 gives A OR B, 1100 gives NOT(A OR B) and 1101 gives A XOR B, each computed bit by bit.
- R2: Select 0010 (trapping add) and 0011 (non-trapping add) both give (A + B) modulo 2^32.
- R3: Select 0110 (trapping subtract) and 1000 (non-trapping subtract) both give (A − B) modulo 2^32.
- R4: For select 0010, the overflow flag is 1 exactly when A and B have the same sign bit and the sign bit of the sum differs from it.
- R5: For select 0110, the overflow flag is 1 exactly when A and B have different sign bits and the sign bit of the difference differs from the sign bit of A.
- R6: For every select other than 0010 and 0110, the overflow flag is 0, including when the non-trapping add or subtract wraps around.
- R7: Select 0111 sets bit 0 to 1 when A < B as two's-complement numbers, and clears bits 31..1. The answer stays correct when A − B overflows.
- R8: Select 1001 sets bit 0 to 1 when A < B as unsigned numbers in 0 to 2^32−1, and clears bits 31..1.
- R9: The zero flag is 1 exactly when all 32 result bits are 0.
- R10: The unused selects (0100, 0101, 1010, 1011, 1110, 1111) give a result of 0 and overflow 0. The zero flag is therefore 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand (A) |
| op_b | input | 32 | Second operand (B) |
| op_sel | input | 4 | Operation select code |
| result | output | 32 | Computed result word |
| zero_flag | output | 1 | High when the result is all zeros |
| ovf_flag | output | 1 | Signed overflow of a trapping add or subtract |

## Verification
The hardest case to reach is a signed compare whose difference overflows. With A = most negative and B = 1, or A = most positive and B = −1, the raw sign of A − B gives the wrong answer, and random operands almost never land there. The stimulus therefore sweeps every select code over a hand-picked set of operand pairs around the extremes (0, 1, −1, most positive, most negative, equal operands). It then adds a long run of pseudo-random pairs. A behavioural model built on wide integers predicts all three outputs for each pair.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    localparam int unsigned SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        OP_AND  = 4'b0000,
        OP_OR   = 4'b0001,
        OP_ADD  = 4'b0010,
        OP_ADDU = 4'b0011,
        OP_SUB  = 4'b0110,
        OP_SLT  = 4'b0111,
        OP_SUBU = 4'b1000,
        OP_SLTU = 4'b1001,
        OP_NOR  = 4'b1100,
        OP_XOR  = 4'b1101
    } alu_op_e;

    typedef enum logic [1:0] {
        GRP_NONE,
        GRP_LOGIC,
        GRP_ARITH,
        GRP_CMP
    } alu_grp_e;

    typedef enum logic [1:0] {
        LG_AND,
        LG_OR,
        LG_NOR,
        LG_XOR
    } logic_fn_e;

    typedef struct packed {
        alu_grp_e  grp;
        logic_fn_e lfn;
        logic      subtract;
        logic      trap;
        logic      unsigned_cmp;
    } alu_ctrl_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             subtract,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             overflow
);
    localparam int unsigned LOW_W = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [LOW_W-1:0] low_sum;
    logic             carry_msb;
    logic             msb_sum;

    assign b_eff = b ^ {WIDTH{subtract}};

    // Lower bits: carry in is the subtract control
    assign {carry_msb, low_sum} = {1'b0, a[LOW_W-1:0]}
                                + {1'b0, b_eff[LOW_W-1:0]}
                                + {{LOW_W{1'b0}}, subtract};

    // Top bit kept apart to expose the carry into it
    assign {carry_out, msb_sum} = {1'b0, a[WIDTH-1]}
                                + {1'b0, b_eff[WIDTH-1]}
                                + {1'b0, carry_msb};

    assign sum      = {msb_sum, low_sum};
    assign overflow = carry_msb ^ carry_out;
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import int_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic_fn_e        fn,
    output logic [WIDTH-1:0] y
);
    always_comb begin
        unique case (fn)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_NOR:  y = ~(a | b);
            LG_XOR:  y = a ^ b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu_less.sv
module alu_less (
    input  logic diff_sign,
    input  logic diff_ovf,
    input  logic carry_out,
    input  logic unsigned_mode,
    output logic less
);
    logic less_signed;
    logic less_unsigned;

    assign less_signed   = diff_sign ^ diff_ovf;
    assign less_unsigned = ~carry_out;
    assign less          = unsigned_mode ? less_unsigned : less_signed;
endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [3:0]       op_sel,
    output logic [WIDTH-1:0] result,
    output logic             zero_flag,
    output logic             ovf_flag
);
    alu_ctrl_t        ctrl;
    logic [WIDTH-1:0] arith_y;
    logic [WIDTH-1:0] logic_y;
    logic             add_cout;
    logic             add_ovf;
    logic             less_bit;

    always_comb begin
        ctrl = '{grp: GRP_NONE, lfn: LG_AND, subtract: 1'b0, trap: 1'b0, unsigned_cmp: 1'b0};
        unique case (op_sel)
            OP_AND:  begin ctrl.grp = GRP_LOGIC; ctrl.lfn = LG_AND; end
            OP_OR:   begin ctrl.grp = GRP_LOGIC; ctrl.lfn = LG_OR;  end
            OP_NOR:  begin ctrl.grp = GRP_LOGIC; ctrl.lfn = LG_NOR; end
            OP_XOR:  begin ctrl.grp = GRP_LOGIC; ctrl.lfn = LG_XOR; end
            OP_ADD:  begin ctrl.grp = GRP_ARITH; ctrl.trap = 1'b1; end
            OP_ADDU: begin ctrl.grp = GRP_ARITH; end
            OP_SUB:  begin ctrl.grp = GRP_ARITH; ctrl.subtract = 1'b1; ctrl.trap = 1'b1; end
            OP_SUBU: begin ctrl.grp = GRP_ARITH; ctrl.subtract = 1'b1; end
            OP_SLT:  begin ctrl.grp = GRP_CMP;   ctrl.subtract = 1'b1; end
            OP_SLTU: begin ctrl.grp = GRP_CMP;   ctrl.subtract = 1'b1; ctrl.unsigned_cmp = 1'b1; end
            default: ;
        endcase
    end

    alu_addsub #(.WIDTH(WIDTH)) i_addsub (
        .a         (op_a),
        .b         (op_b),
        .subtract  (ctrl.subtract),
        .sum       (arith_y),
        .carry_out (add_cout),
        .overflow  (add_ovf)
    );

    alu_bitwise #(.WIDTH(WIDTH)) i_bitwise (
        .a  (op_a),
        .b  (op_b),
        .fn (ctrl.lfn),
        .y  (logic_y)
    );

    alu_less i_less (
        .diff_sign     (arith_y[WIDTH-1]),
        .diff_ovf      (add_ovf),
        .carry_out     (add_cout),
        .unsigned_mode (ctrl.unsigned_cmp),
        .less          (less_bit)
    );

    always_comb begin
        unique case (ctrl.grp)
            GRP_LOGIC: result = logic_y;
            GRP_ARITH: result = arith_y;
            GRP_CMP:   result = {{(WIDTH-1){1'b0}}, less_bit};
            default:   result = '0;
        endcase
    end

    assign zero_flag = ~|result;
    assign ovf_flag  = ctrl.trap & add_ovf;

    // Guards relating ports to the chosen operation
    always_comb begin
        if (!$isunknown({op_sel, op_a, op_b})) begin
            // R6
            a_r6_no_overflow: assert (ovf_flag == 1'b0 || op_sel == OP_ADD || op_sel == OP_SUB);
            // R4
            a_r4_add_ovf_sign: assert (!(op_sel == OP_ADD && ovf_flag) ||
                (op_a[WIDTH-1] == op_b[WIDTH-1] && result[WIDTH-1] != op_a[WIDTH-1]));
            // R7 / R8
            a_r7_cmp_upper_clear: assert (!(op_sel == OP_SLT || op_sel == OP_SLTU) ||
                result[WIDTH-1:1] == '0);
            // R8
            a_r8_unsigned_less: assert (!(op_sel == OP_SLTU) || (result[0] == (op_a < op_b)));
            // R10
            a_r10_unused_zero: assert (ctrl.grp != GRP_NONE || (result == '0 && !ovf_flag));
        end
    end
endmodule

// File: tb/test_int_alu.sv
module test_int_alu;
    localparam int W = 32;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [3:0]   op_sel = 4'b0000;
    logic [W-1:0] result;
    logic         zero_flag;
    logic         ovf_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int_alu #(.WIDTH(W)) i_int_alu (
        .op_a      (op_a),
        .op_b      (op_b),
        .op_sel    (op_sel),
        .result    (result),
        .zero_flag (zero_flag),
        .ovf_flag  (ovf_flag)
    );

    function automatic string res_tag(input logic [3:0] s);
        case (s)
            4'b0000, 4'b0001, 4'b1100, 4'b1101: return "R1";
            4'b0010, 4'b0011: return "R2";
            4'b0110, 4'b1000: return "R3";
            4'b0111: return "R7";
            4'b1001: return "R8";
            default: return "R10";
        endcase
    endfunction

    function automatic string ovf_tag(input logic [3:0] s);
        case (s)
            4'b0010: return "R4";
            4'b0110: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic model(input logic [3:0] s, input logic [W-1:0] a, input logic [W-1:0] b,
                         output logic [W-1:0] r, output logic v);
        longint sa, sb, wide;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        v = 1'b0;
        r = '0;
        case (s)
            4'b0000: r = a & b;
            4'b0001: r = a | b;
            4'b1100: r = ~(a | b);
            4'b1101: r = a ^ b;
            4'b0010, 4'b0011: begin
                wide = sa + sb;
                r = wide[W-1:0];
                if (s == 4'b0010) v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
            end
            4'b0110, 4'b1000: begin
                wide = sa - sb;
                r = wide[W-1:0];
                if (s == 4'b0110) v = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
            end
            4'b0111: r = (sa < sb) ? 1 : 0;
            4'b1001: r = (a < b) ? 1 : 0;
            default: r = '0;
        endcase
    endtask

    task automatic apply(input logic [3:0] s, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] exp_r;
        logic         exp_v;
        @(posedge clk);
        op_sel = s; op_a = a; op_b = b;
        @(negedge clk);
        model(s, a, b, exp_r, exp_v);
        n_checks++;
        if (result !== exp_r) begin
            n_fail++;
            $display("FAIL %s sel=%b a=%h b=%h result actual=%h expected=%h",
                     res_tag(s), s, a, b, result, exp_r);
        end
        n_checks++;
        if (zero_flag !== (exp_r == '0)) begin
            n_fail++;
            $display("FAIL R9 sel=%b a=%h b=%h zero actual=%b expected=%b",
                     s, a, b, zero_flag, (exp_r == '0));
        end
        n_checks++;
        if (ovf_flag !== exp_v) begin
            n_fail++;
            $display("FAIL %s sel=%b a=%h b=%h ovf actual=%b expected=%b",
                     ovf_tag(s), s, a, b, ovf_flag, exp_v);
        end
    endtask

    logic [W-1:0] corner [8];

    initial begin
        corner[0] = 32'h0000_0000;
        corner[1] = 32'h0000_0001;
        corner[2] = 32'hFFFF_FFFF;
        corner[3] = 32'h7FFF_FFFF;
        corner[4] = 32'h8000_0000;
        corner[5] = 32'h0000_0005;
        corner[6] = 32'hFFFF_FFFB;
        corner[7] = 32'hA5A5_5A5A;

        // Named corners: R4 R5 R7 overflow-affected compares, R6 wrap without flag
        apply(4'b0010, 32'h7FFF_FFFF, 32'h0000_0001); // R4 pos+pos -> neg
        apply(4'b0010, 32'h8000_0000, 32'hFFFF_FFFF); // R4 neg+neg -> pos
        apply(4'b0110, 32'h7FFF_FFFF, 32'hFFFF_FFFF); // R5 pos-neg -> neg
        apply(4'b0110, 32'h8000_0000, 32'h0000_0001); // R5 neg-pos -> pos
        apply(4'b0011, 32'h7FFF_FFFF, 32'h0000_0001); // R6 addu wraps silently
        apply(4'b1000, 32'h8000_0000, 32'h0000_0001); // R6 subu wraps silently
        apply(4'b0111, 32'h8000_0000, 32'h0000_0001); // R7 diff overflows, less=1
        apply(4'b0111, 32'h7FFF_FFFF, 32'hFFFF_FFFF); // R7 diff overflows, less=0
        apply(4'b1001, 32'h0000_0001, 32'hFFFF_FFFF); // R8 unsigned less=1
        apply(4'b0110, 32'h1234_5678, 32'h1234_5678); // R9 equal -> zero
        apply(4'b1110, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R10 unused code

        // Every select over all corner pairs
        for (int s = 0; s < 16; s++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    apply(4'(s), corner[i], corner[j]);

        // Pseudo-random operands for all selects
        for (int k = 0; k < 1500; k++) begin
            logic [W-1:0] ra, rb;
            ra = $urandom();
            rb = (k % 4 == 0) ? ra : $urandom();
            for (int s = 0; s < 16; s++)
                apply(4'(s), ra, rb);
        end

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule